// File: doc/BRIEF.md
# Criticality-Aware Operation Dispatcher

This block sits between an issue stage and a small pool of execution units. Every operation arriving on the valid/ready issue port is looked up in a one-bit-per-opcode class table. If the operation is marked timing-critical, it is steered to unit 0, which is reserved for critical work. Otherwise it is steered to one of the remaining units, which are picked in rotating order, and busy units are passed over. Each accepted operation appears exactly once on one unit's dispatch port, one cycle after the issue handshake.

Critical operations are rare, so unit 0 spends most of its time idle. The block counts consecutive cycles in which no critical operation was dispatched. When the count reaches a programmable limit, unit 0 is parked. The way it is parked depends on the mode captured when parking starts:
- **Gating mode:** a power-gate request is raised. A later critical operation first has to wait out a programmable wake-up delay, with the issue port stalled.
- **Vector mode:** a programmable constant operand pair is held on unit 0's operand outputs. A critical operation is taken at once.

Top module: `crit_dispatch`

## Requirements
- R1: After reset every table entry is non-critical (0). A write through the configuration port (`cfg_we`, `cfg_opc`, `cfg_crit`, where 1 means critical) changes how that opcode is routed from the following cycle on.
- R2: An operation whose table bit is 1 is dispatched only on unit 0. For such an operation `iss_ready` is high only when `unit_busy[0]` is low and unit 0 is either running or parked in vector mode.
- R3: An operation whose table bit is 0 is dispatched only on units 1..NUM_NC. The unit is chosen round-robin: the search starts after the last unit chosen and skips units whose `unit_busy` bit is set. `iss_ready` is low when all of these units are busy.
- R4: Each handshake (`iss_valid` and `iss_ready` both high at a clock edge) produces exactly one one-cycle `du_valid` pulse, in the next cycle, on the chosen unit. That unit's opcode and operand outputs carry the issued values.
- R5: Unit 0 parks after `idle_limit` consecutive cycles without a critical dispatch. An `idle_limit` of 0 disables parking.
- R6: In gating mode, `crit_pg_req` is high while unit 0 is parked. When a critical operation is presented to a gated unit, `iss_ready` stays low in that cycle and for max(`wake_lat`,1) further cycles. After that the operation is accepted.
- R7: In vector mode, `crit_vec_on` is high while unit 0 is parked, and unit 0's operand outputs show `park_opa`/`park_opb`. A critical operation is accepted in the cycle it is presented, with no stall.
- R8: The parking mode is sampled when parking starts. Changing `park_vec_mode` (1 = vector, 0 = gating) while unit 0 is parked has no effect on the outputs.
- R9: `crit_pg_req` and `crit_vec_on` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Class table write strobe |
| cfg_opc | input | OPC_W | Opcode to classify |
| cfg_crit | input | 1 | Class to store, 1 = critical |
| idle_limit | input | IDLE_W | Idle cycles before parking, 0 = never park |
| wake_lat | input | WAKE_W | Wake-up cycles after a gated park |
| park_vec_mode | input | 1 | 1 = vector mode, 0 = gating mode |
| park_opa | input | DATA_W | Constant first operand applied while parked |
| park_opb | input | DATA_W | Constant second operand applied while parked |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Issue accept |
| iss_opc | input | OPC_W | Issued opcode |
| iss_opa | input | DATA_W | Issued first operand |
| iss_opb | input | DATA_W | Issued second operand |
| unit_busy | input | NUM_NC+1 | Per-unit busy, bit 0 is the critical unit |
| du_valid | output | NUM_NC+1 | Per-unit dispatch pulse |
| du_opc | output | (NUM_NC+1)*OPC_W | Per-unit opcode, unit u at bits u*OPC_W |
| du_opa | output | (NUM_NC+1)*DATA_W | Per-unit first operand |
| du_opb | output | (NUM_NC+1)*DATA_W | Per-unit second operand |
| crit_pg_req | output | 1 | Power-gate request for unit 0 |
| crit_vec_on | output | 1 | Low-stress vector applied to unit 0 |

## Verification
Some internal faults show up within one or two cycles:
- A corrupted class bit sends an operation to the wrong unit group in the cycle after the handshake.
- A slipped round-robin pointer picks a different non-critical unit on the next non-critical dispatch.

Faults in the idle counter or wake counter take longer to surface. They show up only when the park or wake boundary is reached, as `crit_pg_req` or `crit_vec_on` toggling one cycle early or late, or as `iss_ready` rising a cycle off. A reference model in the bench is compared against the ports on every cycle, so any such shift is reported in the cycle it first occurs.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PARK = 2'd1,
    ST_WAKE = 2'd2
  } park_st_t;
endpackage

// File: rtl/crit_table.sv
module crit_table #(
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OPC_W-1:0] waddr,
  input  logic             wcrit,
  input  logic [OPC_W-1:0] raddr,
  output logic             rcrit
);
  localparam int DEPTH = 1 << OPC_W;

  logic [DEPTH-1:0] cls_q, cls_d;

  always_comb begin
    cls_d = cls_q;
    if (we) cls_d[waddr] = wcrit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cls_q <= '0;
    else        cls_q <= cls_d;
  end

  assign rcrit = cls_q[raddr];

  // R1: a write is visible on the read side one cycle later
  p_tbl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && raddr == waddr) |=> (($past(raddr) != raddr) || (rcrit == $past(wcrit))));
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     busy,
  input  logic             adv,
  output logic             any_free,
  output logic [IDX_W-1:0] pick
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(ptr_q) + k;
      if (c >= N) c = c - N;
      if (!any_free && !busy[c]) begin
        any_free = 1'b1;
        pick     = IDX_W'(c);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (int'(pick) == N - 1) ? '0 : pick + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R3: an advancing grant never lands on a busy unit
  p_skip_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !busy[pick]);
  // R3: after a grant the search origin moves away from the granted unit
  p_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr_q != $past(pick));
endmodule

// File: rtl/idle_ctl.sv
module idle_ctl import dispatch_pkg::*; #(
  parameter int IDLE_W = 8,
  parameter int WAKE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crit_req,
  input  logic              crit_fire,
  input  logic              busy0,
  input  logic              mode_vec,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [WAKE_W-1:0] wake_lat,
  output logic              crit_ok,
  output logic              pg_req,
  output logic              vec_on
);
  park_st_t          st_q, st_d;
  logic [IDLE_W-1:0] cnt_q, cnt_d;
  logic [WAKE_W-1:0] wk_q, wk_d;
  logic              gate_q, gate_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    wk_d   = wk_q;
    gate_d = gate_q;
    case (st_q)
      ST_RUN: begin
        if (crit_fire || idle_limit == '0) begin
          cnt_d = '0;
        end else if (({1'b0, cnt_q} + 1'b1) >= {1'b0, idle_limit}) begin
          st_d   = ST_PARK;
          cnt_d  = '0;
          gate_d = !mode_vec;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PARK: begin
        if (crit_req && gate_q) begin
          st_d = ST_WAKE;
          wk_d = wake_lat;
        end else if (crit_fire) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end
      end
      ST_WAKE: begin
        if (wk_q <= WAKE_W'(1)) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else begin
          wk_d = wk_q - 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      wk_q   <= '0;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wk_q   <= wk_d;
      gate_q <= gate_d;
    end
  end

  assign crit_ok = !busy0 && ((st_q == ST_RUN) || (st_q == ST_PARK && !gate_q));
  assign pg_req  = (st_q == ST_PARK) && gate_q;
  assign vec_on  = (st_q == ST_PARK) && !gate_q;

  // R6: no critical acceptance while waking
  p_wake_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAKE) |-> !crit_fire);
  // R5: parking begins only after a cycle with no critical dispatch
  p_park_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARK && $past(st_q) == ST_RUN) |-> !$past(crit_fire));
  // R7: vector park releases at once on a critical request
  p_vec_nowake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARK && !gate_q && crit_req && !busy0) |=> st_q == ST_RUN);
  // R8: parking mode frozen while parked
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARK && $past(st_q) == ST_PARK) |-> $stable(gate_q));
  // R9: the two idle controls are exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_req && vec_on));
endmodule

// File: rtl/crit_dispatch.sv
module crit_dispatch import dispatch_pkg::*; #(
  parameter int OPC_W  = 4,
  parameter int DATA_W = 16,
  parameter int NUM_NC = 3,
  parameter int IDLE_W = 8,
  parameter int WAKE_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [OPC_W-1:0]             cfg_opc,
  input  logic                         cfg_crit,
  input  logic [IDLE_W-1:0]            idle_limit,
  input  logic [WAKE_W-1:0]            wake_lat,
  input  logic                         park_vec_mode,
  input  logic [DATA_W-1:0]            park_opa,
  input  logic [DATA_W-1:0]            park_opb,
  input  logic                         iss_valid,
  output logic                         iss_ready,
  input  logic [OPC_W-1:0]             iss_opc,
  input  logic [DATA_W-1:0]            iss_opa,
  input  logic [DATA_W-1:0]            iss_opb,
  input  logic [NUM_NC:0]              unit_busy,
  output logic [NUM_NC:0]              du_valid,
  output logic [(NUM_NC+1)*OPC_W-1:0]  du_opc,
  output logic [(NUM_NC+1)*DATA_W-1:0] du_opa,
  output logic [(NUM_NC+1)*DATA_W-1:0] du_opb,
  output logic                         crit_pg_req,
  output logic                         crit_vec_on
);
  localparam int NU    = NUM_NC + 1;
  localparam int IDX_W = (NUM_NC > 1) ? $clog2(NUM_NC) : 1;

  logic             op_crit, crit_ok, nc_free;
  logic             fire, crit_fire, nc_fire;
  logic [IDX_W-1:0] nc_pick;

  crit_table #(.OPC_W(OPC_W)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .waddr (cfg_opc),
    .wcrit (cfg_crit),
    .raddr (iss_opc),
    .rcrit (op_crit)
  );

  rr_pick #(.N(NUM_NC), .IDX_W(IDX_W)) u_rr (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (unit_busy[NU-1:1]),
    .adv      (nc_fire),
    .any_free (nc_free),
    .pick     (nc_pick)
  );

  idle_ctl #(.IDLE_W(IDLE_W), .WAKE_W(WAKE_W)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .crit_req   (iss_valid && op_crit),
    .crit_fire  (crit_fire),
    .busy0      (unit_busy[0]),
    .mode_vec   (park_vec_mode),
    .idle_limit (idle_limit),
    .wake_lat   (wake_lat),
    .crit_ok    (crit_ok),
    .pg_req     (crit_pg_req),
    .vec_on     (crit_vec_on)
  );

  assign iss_ready = op_crit ? crit_ok : nc_free;
  assign fire      = iss_valid && iss_ready;
  assign crit_fire = fire && op_crit;
  assign nc_fire   = fire && !op_crit;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic              take;
    logic              v_q;
    logic [OPC_W-1:0]  op_q;
    logic [DATA_W-1:0] a_q, b_q;

    if (u == 0) begin : g_crit
      assign take = crit_fire;
    end else begin : g_nc
      assign take = nc_fire && (nc_pick == IDX_W'(u - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q  <= 1'b0;
        op_q <= '0;
        a_q  <= '0;
        b_q  <= '0;
      end else begin
        v_q <= take;
        if (take) begin
          op_q <= iss_opc;
          a_q  <= iss_opa;
          b_q  <= iss_opb;
        end
      end
    end

    assign du_valid[u]                 = v_q;
    assign du_opc[u*OPC_W +: OPC_W]    = op_q;
    if (u == 0) begin : g_vec
      assign du_opa[u*DATA_W +: DATA_W] = crit_vec_on ? park_opa : a_q;
      assign du_opb[u*DATA_W +: DATA_W] = crit_vec_on ? park_opb : b_q;
    end else begin : g_plain
      assign du_opa[u*DATA_W +: DATA_W] = a_q;
      assign du_opb[u*DATA_W +: DATA_W] = b_q;
    end
  end

  // R4: at most one unit pulses per cycle
  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(du_valid));
  // R4: every handshake yields exactly one pulse next cycle
  p_exactly_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $countones(du_valid) == 1);
  // R2: critical work lands on unit 0
  p_crit_u0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    crit_fire |=> du_valid[0]);
  // R3: non-critical work never lands on unit 0
  p_nc_not_u0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nc_fire |=> !du_valid[0]);
endmodule

// File: tb/crit_dispatch_test.sv
module crit_dispatch_test;
  localparam int NNC = 3;
  localparam int NU  = NNC + 1;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic        cfg_we, cfg_crit, park_vec_mode, iss_valid, iss_ready;
  logic [3:0]  cfg_opc, wake_lat, iss_opc;
  logic [7:0]  idle_limit;
  logic [15:0] park_opa, park_opb, iss_opa, iss_opb;
  logic [3:0]  unit_busy, du_valid;
  logic [15:0] du_opc;
  logic [63:0] du_opa, du_opb;
  logic        crit_pg_req, crit_vec_on;

  crit_dispatch uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_opc(cfg_opc), .cfg_crit(cfg_crit),
    .idle_limit(idle_limit), .wake_lat(wake_lat), .park_vec_mode(park_vec_mode),
    .park_opa(park_opa), .park_opb(park_opb), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_opc(iss_opc), .iss_opa(iss_opa), .iss_opb(iss_opb), .unit_busy(unit_busy),
    .du_valid(du_valid), .du_opc(du_opc), .du_opa(du_opa), .du_opb(du_opb),
    .crit_pg_req(crit_pg_req), .crit_vec_on(crit_vec_on)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit          mtbl [16];
  int          ms = 0;      // 0 run, 1 parked, 2 waking
  int          midle = 0, mwake = 0, mrr = 0;
  bit          mgate = 0;
  bit  [3:0]   eDv = '0;
  bit  [3:0]   eOp [NU];
  bit  [15:0]  eA [NU];
  bit  [15:0]  eB [NU];
  bit          eCl [NU];
  int          nfire = 0, ndisp = 0;
  bit          last_fire;

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    bit cls, mrdy, vexp;
    int pick;
    #2;
    cls  = mtbl[iss_opc];
    pick = -1;
    if (cls) mrdy = !unit_busy[0] && (ms == 0 || (ms == 1 && !mgate));
    else begin
      for (int k = 0; k < NNC; k++) begin
        int c;
        c = (mrr + k) % NNC;
        if (pick < 0 && !unit_busy[c+1]) pick = c;
      end
      mrdy = (pick >= 0);
    end
    chk(iss_ready === mrdy, cls ? "R2" : "R3", iss_ready, mrdy);
    chk(du_valid === eDv, "R4", du_valid, eDv);
    for (int u = 0; u < NU; u++) begin
      if (du_valid[u]) ndisp++;
      if (eDv[u]) begin
        chk(du_opc[u*4 +: 4] === eOp[u], "R4", du_opc[u*4 +: 4], eOp[u]);
        if (u > 0) begin
          chk(du_opa[u*16 +: 16] === eA[u], "R4", du_opa[u*16 +: 16], eA[u]);
          chk(du_opb[u*16 +: 16] === eB[u], "R4", du_opb[u*16 +: 16], eB[u]);
        end
      end
      if (u > 0 && du_valid[u]) chk(!eCl[u], "R2", eCl[u], 0);
    end
    vexp = (ms == 1) && !mgate;
    chk(crit_pg_req === ((ms == 1) && mgate), "R6", crit_pg_req, (ms == 1) && mgate);
    chk(crit_vec_on === vexp, "R7", crit_vec_on, vexp);
    if (vexp || eDv[0]) begin
      chk(du_opa[15:0] === (vexp ? park_opa : eA[0]), "R7", du_opa[15:0], vexp ? park_opa : eA[0]);
      chk(du_opb[15:0] === (vexp ? park_opb : eB[0]), "R7", du_opb[15:0], vexp ? park_opb : eB[0]);
    end
    chk(!(crit_pg_req && crit_vec_on), "R9", {crit_pg_req, crit_vec_on}, 0);
    // advance the model
    last_fire = iss_valid && mrdy;
    eDv = '0;
    if (last_fire) begin
      int u;
      u = cls ? 0 : pick + 1;
      eDv[u] = 1'b1; eOp[u] = iss_opc; eA[u] = iss_opa; eB[u] = iss_opb; eCl[u] = cls;
      if (!cls) mrdy = 1'b1;
      if (!cls) mrr = (pick + 1) % NNC;
      nfire++;
    end
    case (ms)
      0: begin
        if ((last_fire && cls) || idle_limit == 0) midle = 0;
        else if (midle + 1 >= int'(idle_limit)) begin ms = 1; midle = 0; mgate = !park_vec_mode; end
        else midle++;
      end
      1: begin
        if (iss_valid && cls && mgate) begin ms = 2; mwake = int'(wake_lat); end
        else if (last_fire && cls) begin ms = 0; midle = 0; end
      end
      default: begin
        if (mwake <= 1) begin ms = 0; midle = 0; end
        else mwake--;
      end
    endcase
    if (cfg_we) mtbl[cfg_opc] = cfg_crit;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    iss_valid = 1'b1; iss_opc = op; iss_opa = a; iss_opb = b;
    step();
    iss_valid = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] op, input bit c);
    cfg_we = 1'b1; cfg_opc = op; cfg_crit = c;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int stalls;
    int unsigned seed;
    for (int i = 0; i < 16; i++) mtbl[i] = 1'b0;
    for (int u = 0; u < NU; u++) begin eOp[u] = '0; eA[u] = '0; eB[u] = '0; eCl[u] = 1'b0; end
    rst_n = 1'b0; cfg_we = 0; cfg_opc = 0; cfg_crit = 0; idle_limit = 0; wake_lat = 3;
    park_vec_mode = 0; park_opa = 16'h5A5A; park_opb = 16'hA5A5; iss_valid = 0;
    iss_opc = 0; iss_opa = 0; iss_opb = 0; unit_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, every opcode non-critical
    iss_opc = 4'd3;
    step();
    chk(du_valid === 4'b0, "R1", du_valid, 0);
    issue(4'd3, 16'h0011, 16'h0022);
    chk(du_valid === 4'b0010, "R1", du_valid, 4'b0010);

    // R1: classify opcodes 3 and 9 as critical
    cfg(4'd3, 1'b1);
    cfg(4'd9, 1'b1);

    // R3: rotation over free units
    for (int i = 0; i < 4; i++) issue(4'd1, 16'h100 + 16'(i), 16'h200 + 16'(i));
    // R3: skip a busy unit
    unit_busy = 4'b0100;
    for (int i = 0; i < 3; i++) issue(4'd2, 16'h300 + 16'(i), 16'h0);
    // R3: all non-critical units busy
    unit_busy = 4'b1110;
    iss_valid = 1'b1; iss_opc = 4'd6;
    #2 chk(iss_ready === 1'b0, "R3", iss_ready, 0);
    step();
    iss_valid = 1'b0; unit_busy = 4'b0000;

    // R2: critical ops to unit 0
    issue(4'd3, 16'hC0DE, 16'hBEEF);
    chk(du_valid === 4'b0001, "R2", du_valid, 4'b0001);
    issue(4'd9, 16'h1234, 16'h4321);

    // R5: park after 4 idle cycles (gating mode)
    idle_limit = 8'd4; park_vec_mode = 1'b0; wake_lat = 4'd3;
    repeat (3) step();
    chk(crit_pg_req === 1'b0, "R5", crit_pg_req, 0);
    step();
    chk(crit_pg_req === 1'b1, "R5", crit_pg_req, 1);

    // R8: mode change while parked is ignored
    park_vec_mode = 1'b1;
    step();
    chk(crit_pg_req === 1'b1 && crit_vec_on === 1'b0, "R8", {crit_pg_req, crit_vec_on}, 2'b10);
    park_vec_mode = 1'b0;

    // R6: wake stall
    stalls = 0;
    iss_valid = 1'b1; iss_opc = 4'd3; iss_opa = 16'h0A0A; iss_opb = 16'h0B0B;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (!iss_ready) begin stalls++; #1; step(); end
      else break;
    end
    chk(stalls == 4, "R6", stalls, 4);
    step();
    iss_valid = 1'b0;

    // R7: vector mode parking
    park_vec_mode = 1'b1;
    repeat (4) step();
    chk(crit_vec_on === 1'b1, "R7", crit_vec_on, 1);
    chk(du_opa[15:0] === 16'h5A5A, "R7", du_opa[15:0], 16'h5A5A);
    iss_valid = 1'b1; iss_opc = 4'd9; iss_opa = 16'h7777; iss_opb = 16'h8888;
    #1 chk(iss_ready === 1'b1, "R7", iss_ready, 1);
    #1;
    step();
    iss_valid = 1'b0;
    chk(du_valid === 4'b0001 && du_opa[15:0] === 16'h7777, "R7", du_opa[15:0], 16'h7777);

    // R1: reclassify opcode 5 while issuing it
    cfg_we = 1'b1; cfg_opc = 4'd5; cfg_crit = 1'b1;
    iss_valid = 1'b1; iss_opc = 4'd5; iss_opa = 16'h5555;
    step();
    cfg_we = 1'b0;
    chk(du_valid[0] === 1'b0, "R1", du_valid, 0);
    step();
    iss_valid = 1'b0;
    chk(du_valid === 4'b0001, "R1", du_valid, 4'b0001);

    // mixed random traffic
    idle_limit = 8'd3; wake_lat = 4'd2;
    seed = 32'h1ACE5EED;
    for (int i = 0; i < 600; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      iss_valid = seed[17] | seed[18];
      iss_opc   = seed[23:20];
      iss_opa   = seed[31:16];
      iss_opb   = seed[15:0];
      unit_busy = seed[27:24] & {4{seed[29]}};
      park_vec_mode = seed[30];
      if (i % 97 == 50) iss_valid = 1'b0;
      step();
    end
    iss_valid = 1'b0; unit_busy = 4'b0;
    step();
    // R4: every accepted op dispatched exactly once
    chk(nfire == ndisp, "R4", ndisp, nfire);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule